// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block decides whether a received CAN frame header is kept. It holds a row of mask-mode filter banks. Each bank has two 32-bit words, a scale bit and an activation bit. A bank with its scale bit set acts as one wide filter for extended or standard identifiers: the first word is the identifier pattern and the second word is the mask. A bank with its scale bit clear acts as two narrow filters. In that case each word carries its own pattern in the low half and its own mask in the high half.

Configuration goes through a small write port, and writes take effect only while the initialisation input is held high. A frame parser elsewhere presents the identifier, the IDE flag and the RTR flag with a one-cycle strobe. One clock later the block returns a one-cycle result: accept or reject, and the number of the lowest-numbered filter that matched. Filters are numbered in rising bank order. A wide bank takes one number and a narrow bank takes two.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every bank is inactive, its words are zero and its scale bit is clear, and `res_valid` is low. A frame sent straight after reset therefore gives a result that is rejected.
- R2: Write address map. An address of 2·b writes the first word of bank b, and 2·b+1 writes its second word. Address 2·NUM_BANKS writes the scale bits, with bit b belonging to bank b. Address 2·NUM_BANKS+1 writes the activation bits in the same way. A write is ignored unless `cfg_init` is high in the same cycle.
- R3: Wide-scale compare vector. Bits 31:21 hold the standard identifier (for an extended frame, identifier bits 28:18). Bits 20:3 hold extended identifier bits 17:0, which are zero for a standard frame. Bit 2 is IDE, bit 1 is RTR and bit 0 is zero.
- R4: Narrow-scale compare vector. Bits 15:5 hold the standard identifier, bit 4 is RTR and bit 3 is IDE. Bits 2:0 hold extended identifier bits 17:15, which are zero for a standard frame. Each word of a narrow bank is one filter: bits 15:0 are the pattern and bits 31:16 are the mask.
- R5: Where a mask bit is 1, the received bit must equal the pattern bit. Where a mask bit is 0, the received bit is not compared.
- R6: Only banks whose activation bit is set can produce a match.
- R7: While `cfg_init` is high, a frame strobe is ignored and no result is produced.
- R8: The first filter of bank b has the number 2·b minus the count of wide banks below b. The second word of a narrow bank is that number plus one. This numbering covers every bank, active or not.
- R9: When several filters match, the lowest filter number is reported.
- R10: A strobe in cycle t gives `res_valid` high in cycle t+1 only. On a reject, `res_accept` and `res_index` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_init | input | 1 | Initialisation: enables writes and suspends matching |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | ADDR_W | Write address (see R2) |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Frame header strobe |
| rx_ide | input | 1 | Frame uses an extended identifier |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_id | input | 29 | Identifier; a standard frame uses bits 10:0 |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame matched an active filter |
| res_index | output | IDX_W | Number of the winning filter |

## Verification
The assertions assume that the configuration changes only while `cfg_init` is high. They also assume that `rx_valid` is a single-cycle strobe whose header fields are stable in that cycle. The bench meets this by loading banks only inside an initialisation window. It drives every frame strobe for exactly one cycle, and it always returns `cfg_init` low before sending any frame that must be matched. The one frame sent with `cfg_init` high is there to check that frames are dropped during initialisation. Each configuration step keeps a known set of banks active, so every expected filter number follows from the numbering rule alone.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  typedef struct packed {
    logic        ide;
    logic        rtr;
    logic [28:0] id;
  } can_hdr_t;

  // Standard identifier part of the header.
  function automatic logic [10:0] hdr_std(can_hdr_t h);
    return h.ide ? h.id[28:18] : h.id[10:0];
  endfunction

  // Extended low part; zero for standard frames.
  function automatic logic [17:0] hdr_ext(can_hdr_t h);
    return h.ide ? h.id[17:0] : 18'd0;
  endfunction

  // Wide-scale compare vector.
  function automatic logic [31:0] rx_vec32(can_hdr_t h);
    return {hdr_std(h), hdr_ext(h), h.ide, h.rtr, 1'b0};
  endfunction

  // Narrow-scale compare vector.
  function automatic logic [15:0] rx_vec16(can_hdr_t h);
    logic [17:0] e;
    e = hdr_ext(h);
    return {hdr_std(h), h.rtr, h.ide, e[17:15]};
  endfunction

  function automatic logic hit32(logic [31:0] rx, logic [31:0] pat, logic [31:0] msk);
    return ((rx ^ pat) & msk) == 32'd0;
  endfunction

  function automatic logic hit16(logic [15:0] rx, logic [31:0] word);
    return ((rx ^ word[15:0]) & word[31:16]) == 16'd0;
  endfunction

  // Number of the first filter in a bank: two per narrow bank below it, one per wide bank.
  function automatic int filt_base(logic [63:0] scale, int bank);
    int n;
    n = 0;
    for (int j = 0; j < 64; j++) begin
      if (j < bank) n = n + (scale[j] ? 1 : 2);
    end
    return n;
  endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs #(
  parameter int NB = 14,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   word_a [NB],
  output logic [31:0]   word_b [NB],
  output logic [NB-1:0] scale,
  output logic [NB-1:0] act
);
  localparam int SCALE_ADDR = 2 * NB;
  localparam int ACT_ADDR   = 2 * NB + 1;

  logic wr_ok;
  assign wr_ok = init & we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        word_a[b] <= '0;
        word_b[b] <= '0;
      end
      scale <= '0;
      act   <= '0;
    end else if (wr_ok) begin
      for (int b = 0; b < NB; b++) begin
        if (addr == AW'(2 * b))     word_a[b] <= wdata;
        if (addr == AW'(2 * b + 1)) word_b[b] <= wdata;
      end
      if (addr == AW'(SCALE_ADDR)) scale <= wdata[NB-1:0];
      if (addr == AW'(ACT_ADDR))   act   <= wdata[NB-1:0];
    end
  end

endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  logic [31:0] rx32,
  input  logic [15:0] rx16,
  input  logic [31:0] word_a,
  input  logic [31:0] word_b,
  input  logic        wide,
  input  logic        active,
  output logic        hit_lo,
  output logic        hit_hi
);
  logic wide_hit, half_a, half_b;

  assign wide_hit = hit32(rx32, word_a, word_b);
  assign half_a   = hit16(rx16, word_a);
  assign half_b   = hit16(rx16, word_b);

  assign hit_lo = active & (wide ? wide_hit : half_a);
  assign hit_hi = active & ~wide & half_b;

endmodule

// File: rtl/can_filt_pick.sv
module can_filt_pick
  import can_filt_pkg::*;
#(
  parameter int NB = 14,
  parameter int IW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [2*NB-1:0] slot_hit,
  input  logic [NB-1:0]   scale,
  output logic            any_hit,
  output logic            res_valid,
  output logic            res_accept,
  output logic [IW-1:0]   res_index
);
  logic [IW-1:0] idx_c;

  // Walk from the top slot down so the last assignment is the lowest match.
  always_comb begin
    any_hit = 1'b0;
    idx_c   = '0;
    for (int s = 2 * NB - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        any_hit = 1'b1;
        idx_c   = IW'(filt_base(64'(scale), s / 2) + (s % 2));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= fire;
      res_accept <= fire & any_hit;
      res_index  <= (fire & any_hit) ? idx_c : '0;
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter  int NUM_BANKS = 14,
  localparam int ADDR_W    = $clog2(2 * NUM_BANKS + 2),
  localparam int IDX_W     = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_init,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  input  logic [28:0]       rx_id,
  output logic              res_valid,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_index
);
  logic [31:0]            word_a [NUM_BANKS];
  logic [31:0]            word_b [NUM_BANKS];
  logic [NUM_BANKS-1:0]   scale_q;
  logic [NUM_BANKS-1:0]   act_q;
  logic [2*NUM_BANKS-1:0] slot_hit;
  can_hdr_t               hdr;
  logic [31:0]            rx32;
  logic [15:0]            rx16;
  logic                   fire;
  logic                   any_hit;

  assign hdr  = '{ide: rx_ide, rtr: rx_rtr, id: rx_id};
  assign rx32 = rx_vec32(hdr);
  assign rx16 = rx_vec16(hdr);
  assign fire = rx_valid & ~cfg_init;

  can_filt_regs #(.NB(NUM_BANKS), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .init(cfg_init), .we(cfg_we),
    .addr(cfg_addr), .wdata(cfg_wdata),
    .word_a(word_a), .word_b(word_b), .scale(scale_q), .act(act_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    can_filt_bank u_bank (
      .rx32(rx32), .rx16(rx16),
      .word_a(word_a[b]), .word_b(word_b[b]),
      .wide(scale_q[b]), .active(act_q[b]),
      .hit_lo(slot_hit[2*b]), .hit_hi(slot_hit[2*b+1])
    );
  end

  can_filt_pick #(.NB(NUM_BANKS), .IW(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .fire(fire), .slot_hit(slot_hit),
    .scale(scale_q), .any_hit(any_hit),
    .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index)
  );

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
  parameter int NB = 14,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_init,
  input logic          rx_valid,
  input logic          res_valid,
  input logic          res_accept,
  input logic [IW-1:0] res_index,
  input logic [NB-1:0] act,
  input logic [NB-1:0] scale,
  input logic          any_hit
);

  p_result_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rx_valid && !cfg_init));

  p_init_drops_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> !res_valid);

  p_reject_zero_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_index == '0));

  p_index_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (res_valid && (int'(res_index) < 2 * NB)));

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_init |=> ($stable(act) && $stable(scale)));

  p_needs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> ($past(act) != '0));

  p_accept_from_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> $past(any_hit));

endmodule

bind can_accept_filter can_filt_chk #(.NB(NUM_BANKS), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .rx_valid(rx_valid),
  .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index),
  .act(act_q), .scale(scale_q), .any_hit(any_hit)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  localparam int NB = 14;
  localparam int AW = 5;
  localparam int IW = 5;
  localparam int SCALE_A = 2 * NB;
  localparam int ACT_A   = 2 * NB + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_init = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ide = 1'b0;
  logic          rx_rtr = 1'b0;
  logic [28:0]   rx_id = '0;
  logic          res_valid, res_accept;
  logic [IW-1:0] res_index;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  can_accept_filter #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rx_valid(rx_valid),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_id(rx_id),
    .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index)
  );

  // Vector: {ide, rtr, id[28:0], accept, index[4:0]}
  localparam logic [36:0] VEC [7] = '{
    {1'b1, 1'b0, 29'h1234567, 1'b1, 5'd0},  // wide exact, narrow catch-all also hits: R9
    {1'b1, 1'b1, 29'h1234567, 1'b1, 5'd0},  // RTR not compared: R5
    {1'b1, 1'b0, 29'h1234566, 1'b1, 5'd4},  // one id bit off: R3
    {1'b0, 1'b0, 29'h0000123, 1'b1, 5'd1},  // narrow exact, both halves hit: R4
    {1'b0, 1'b0, 29'h00001AB, 1'b1, 5'd2},  // upper-bits mask: R5
    {1'b0, 1'b0, 29'h00002AB, 1'b1, 5'd4},  // falls to catch-all
    {1'b0, 1'b1, 29'h0000123, 1'b1, 5'd1}   // narrow RTR not compared: R4
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Strobe for one cycle; outputs are read at the following falling edge.
  task automatic send(logic ide, logic rtr, logic [28:0] id);
    @(negedge clk);
    rx_valid = 1'b1; rx_ide = ide; rx_rtr = rtr; rx_id = id;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_res(string req, logic v, logic a, logic [IW-1:0] idx);
    check({req, " valid"}, 32'(res_valid), 32'(v));
    check({req, " accept"}, 32'(res_accept), 32'(a));
    check({req, " index"}, 32'(res_index), 32'(idx));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a frame with all banks inactive is rejected
    check("R1 idle valid", 32'(res_valid), 32'd0);
    send(1'b0, 1'b0, 29'h0);
    expect_res("R1", 1'b1, 1'b0, '0);
    @(negedge clk);
    check("R10 pulse ends", 32'(res_valid), 32'd0);

    // Configure (R2 address map)
    cfg_init = 1'b1;
    wr(0, {29'h1234567, 1'b1, 1'b0, 1'b0});
    wr(1, 32'hFFFF_FFFC);
    wr(2, {16'hFFE8, 16'h2460});
    wr(3, {16'hE008, 16'h2000});
    wr(4, 32'h0); wr(5, 32'h0);
    wr(6, 32'h0); wr(7, 32'h0);
    wr(SCALE_A, 32'b0101);
    wr(ACT_A, 32'b1011);
    @(negedge clk);
    cfg_init = 1'b0;

    for (int i = 0; i < 7; i++) begin
      send(VEC[i][36], VEC[i][35], VEC[i][34:6]);
      expect_res($sformatf("R3 R4 R5 R9 vec%0d", i), 1'b1, VEC[i][5], VEC[i][4:0]);
    end

    // R7: strobe during initialisation gives no result
    cfg_init = 1'b1;
    send(1'b0, 1'b0, 29'h123);
    check("R7 no result", 32'(res_valid), 32'd0);
    @(negedge clk);
    cfg_init = 1'b0;

    // R2: write with init low is ignored
    wr(ACT_A, 32'h0);
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R2 ignored write", 1'b1, 1'b1, 5'd4);

    // R6: drop bank 3; inactive wide catch-all in bank 2 must not hit
    cfg_init = 1'b1; wr(ACT_A, 32'b0011); @(negedge clk); cfg_init = 1'b0;
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R6 reject", 1'b1, 1'b0, '0);

    // R6 R8: enable bank 2 (wide, base 1+2=3)
    cfg_init = 1'b1; wr(ACT_A, 32'b0111); @(negedge clk); cfg_init = 1'b0;
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R6 R8 bank2", 1'b1, 1'b1, 5'd3);

    // R8: only bank 3, all narrow -> base 6
    cfg_init = 1'b1; wr(ACT_A, 32'b1000); wr(SCALE_A, 32'h0); @(negedge clk); cfg_init = 1'b0;
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R8 narrow base", 1'b1, 1'b1, 5'd6);

    // R8: banks 0..3 wide -> base 3
    cfg_init = 1'b1; wr(SCALE_A, 32'b1111); @(negedge clk); cfg_init = 1'b0;
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R8 wide base", 1'b1, 1'b1, 5'd3);

    // R8: top bank, narrow, first half catch-all -> 26
    cfg_init = 1'b1; wr(ACT_A, 32'h2000); wr(SCALE_A, 32'h0); @(negedge clk); cfg_init = 1'b0;
    send(1'b1, 1'b0, 29'h1FFFFFFF);
    expect_res("R8 top bank", 1'b1, 1'b1, 5'd26);

    // R9 R4: first half no longer matches, second half does -> 27
    cfg_init = 1'b1; wr(26, 32'hFFFF_FFFF); @(negedge clk); cfg_init = 1'b0;
    send(1'b0, 1'b0, 29'h2AB);
    expect_res("R9 second half", 1'b1, 1'b1, 5'd27);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule